// File: doc/BRIEF.md
# TDM Per-Channel Loopback Selector

This block sits in the transmit path of a framed TDM serial link. Each bit time it passes one bit to the line. For every 8-bit channel timeslot it chooses the source of that bit. The source is either the backplane transmit stream or the same timeslot of the stream received from the line. The choice is held in a per-channel enable bitmap, which software reads and writes through a small byte-wide register port. Any subset of channels may be looped, from none to all.

Transmit and receive share one bit clock (`clk`, one bit per cycle) and one frame sync. The frame layout is set by a parameter:
- With 32 channels (E1-like), a frame is 256 bits.
- With 24 channels (T1-like), a frame is 193 bits. One framing bit comes first and always passes through from the backplane.

The serial streams run at line rate and cannot be stalled. For that reason they are plain one-bit pins and have no valid/ready handshake. The source for a channel is fixed at that channel's first bit, so a timeslot never mixes its two sources.

Top module: `tdm_chan_loop`

## Requirements
- R1: In a payload bit time of a channel whose latched enable is 1, `tx_out` equals `rx_in` in the same cycle.
- R2: In a payload bit time of a channel whose latched enable is 0, `tx_out` equals `tx_in` in the same cycle.
- R3: While `rst_n` is low, and after it is released, every enable bit is 0. Every register reads 0x00 until it is written.
- R4: The bitmap is held in four byte registers, starting at `BASE_ADDR` (default 0x4B):
  - 0x4B holds channels 1..8.
  - 0x4C holds channels 9..16.
  - 0x4D holds channels 17..24.
  - 0x4E holds channels 25..32.
  - In each register, bit 0 is the lowest-numbered channel.
  - A write (`reg_wr`=1) updates the register at the clock edge, and `reg_rdata` returns it combinationally.
  - Other addresses read 0x00, and writes to them change nothing.
- R5: Any combination of the 32 enable bits is accepted, and each channel follows only its own bit.
- R6: The cycle in which `fsync` is 1 is frame bit 0, at any point in a frame. Without `fsync`, the position advances by one each cycle and wraps to 0 after the last bit of the frame.
- R7: With `NUM_CH`=24, frame bit 0 is the framing bit. Channel 1 starts at bit 1, and `tx_out` equals `tx_in` on the framing bit. With `NUM_CH`=32, channel 1 starts at bit 0.
- R8: Channel k (counting from 1) takes 8 consecutive bits. The enable is sampled from the register value at the channel's first bit and held for all 8 bits. A write made in the middle of a channel takes effect from the next channel.
- R9: With `NUM_CH`=24, the enable bits of channels 25..32 are stored and read back but never affect `tx_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, marks frame bit 0 |
| tx_in | input | 1 | Transmit serial data from the backplane |
| rx_in | input | 1 | Receive serial data from the line |
| tx_out | output | 1 | Transmit serial data after substitution |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench builds two copies of the block side by side, one with `NUM_CH`=32 and one with `NUM_CH`=24. Both get the same pseudo-random serial data and the same register traffic, so every bitmap exercises both frame layouts. These include a walking single channel, all-on, all-off, alternating patterns and random maps.

Because every cycle of every frame is compared against an arithmetic model of the frame position, several cases are covered directly:
- writes that land mid-channel;
- frame syncs forced mid-frame;
- the framing bit;
- the ignored upper enable bits in the 24-channel build.

// File: rtl/tdm_loop_pkg.sv
`timescale 1ns/1ps
package tdm_loop_pkg;
  localparam int CH_BITS = 8;
  localparam int MAX_CH  = 32;
  localparam int NREG    = MAX_CH / CH_BITS;
  typedef logic [7:0]        byte_t;
  typedef logic [MAX_CH-1:0] chmap_t;
endpackage

// File: rtl/tdm_slot_counter.sv
`timescale 1ns/1ps
module tdm_slot_counter #(
  parameter int NUM_CH = 32,
  parameter int FBITS  = 0,
  parameter int PW     = 8,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  output logic          in_fbit,
  output logic          first_bit,
  output logic [CW-1:0] ch_idx
);
  import tdm_loop_pkg::*;
  localparam int FRAME_BITS = NUM_CH * CH_BITS + FBITS;
  localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

  logic [PW-1:0] pos_q, pos_cur, payload;

  assign pos_cur = fsync ? '0 : pos_q;
  assign payload = pos_cur - PW'(FBITS);

  generate
    if (FBITS > 0) begin : g_fbit
      assign in_fbit = (pos_cur < PW'(FBITS));
    end else begin : g_nofbit
      assign in_fbit = 1'b0;
    end
  endgenerate

  assign first_bit = !in_fbit && (payload[2:0] == 3'd0);
  assign ch_idx    = payload[PW-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pos_q <= '0;
    else if (pos_cur == LAST) pos_q <= '0;
    else                      pos_q <= pos_cur + 1'b1;
  end

  // R6: a sync pulse puts the next cycle at frame bit 1
  a_r6_fsync_align: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (pos_q == PW'(1)));
  // R6: the last frame bit is followed by bit 0
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_cur == LAST) |=> (pos_q == '0));
endmodule

// File: rtl/tdm_loop_regs.sv
`timescale 1ns/1ps
module tdm_loop_regs #(
  parameter logic [7:0] BASE_ADDR = 8'h4B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output tdm_loop_pkg::chmap_t chmap
);
  import tdm_loop_pkg::*;

  byte_t           regs_q [NREG];
  logic [NREG-1:0] hit;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      assign hit[i] = (reg_addr == BASE_ADDR + 8'(i));
      assign chmap[CH_BITS*i +: CH_BITS] = regs_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                regs_q[i] <= '0;
        else if (reg_wr && hit[i]) regs_q[i] <= reg_wdata;
      end

      // R4: a write lands in its register at the next edge
      a_r4_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit[i]) |=> (regs_q[i] == $past(reg_wdata)));
      // R3: reset leaves every enable cleared
      a_r3_reset_clear: assert property (@(posedge clk)
        (!rst_n && !reg_wr) |=> (regs_q[i] == '0));
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) reg_rdata = regs_q[i];
  end
endmodule

// File: rtl/tdm_loop_mux.sv
`timescale 1ns/1ps
module tdm_loop_mux #(
  parameter int CW = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_fbit,
  input  logic                 first_bit,
  input  logic [CW-1:0]        ch_idx,
  input  tdm_loop_pkg::chmap_t chmap,
  input  logic                 tx_in,
  input  logic                 rx_in,
  output logic                 tx_out
);
  logic sel, hold_q;

  always_comb begin
    if (in_fbit)        sel = 1'b0;
    else if (first_bit) sel = chmap[ch_idx];
    else                sel = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= sel;
  end

  assign tx_out = sel ? rx_in : tx_in;

  // R8: the source stays fixed inside a channel
  a_r8_no_mix: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_bit && !in_fbit) |-> $stable(sel));
  // R7: the framing bit always comes from the backplane
  a_r7_fbit_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_fbit |-> (tx_out == tx_in));
endmodule

// File: rtl/tdm_chan_loop.sv
`timescale 1ns/1ps
module tdm_chan_loop #(
  parameter int         NUM_CH    = 32,
  parameter logic [7:0] BASE_ADDR = 8'h4B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync,
  input  logic       tx_in,
  input  logic       rx_in,
  output logic       tx_out,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  import tdm_loop_pkg::*;
  localparam int FBITS      = (NUM_CH == 24) ? 1 : 0;
  localparam int FRAME_BITS = NUM_CH * CH_BITS + FBITS;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int CW         = PW - 3;

  logic          in_fbit, first_bit;
  logic [CW-1:0] ch_idx;
  chmap_t        chmap;

  tdm_slot_counter #(.NUM_CH(NUM_CH), .FBITS(FBITS), .PW(PW), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .in_fbit(in_fbit), .first_bit(first_bit), .ch_idx(ch_idx)
  );

  tdm_loop_regs #(.BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chmap(chmap)
  );

  tdm_loop_mux #(.CW(CW)) u_mux (
    .clk(clk), .rst_n(rst_n), .in_fbit(in_fbit), .first_bit(first_bit),
    .ch_idx(ch_idx), .chmap(chmap), .tx_in(tx_in), .rx_in(rx_in),
    .tx_out(tx_out)
  );
endmodule

// File: tb/tdm_chan_loop_tb.sv
`timescale 1ns/1ps
module tdm_chan_loop_tb;
  localparam int LEN_E = 256;
  localparam int LEN_T = 193;

  logic clk = 0;
  logic rst_n = 0;
  logic fs_e = 0, fs_t = 0, tx = 0, rx = 0, wr = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic out_e, out_t;
  logic [7:0] rd_e, rd_t;

  int total = 0, bad = 0;
  int pos_e = 0, pos_t = 0;
  logic hold_e = 0, hold_t = 0;
  logic [31:0] map_m = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  tdm_chan_loop #(.NUM_CH(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fs_e), .tx_in(tx), .rx_in(rx),
    .tx_out(out_e), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rd_e));

  tdm_chan_loop #(.NUM_CH(24)) u_dut_t1 (
    .clk(clk), .rst_n(rst_n), .fsync(fs_t), .tx_in(tx), .rx_in(rx),
    .tx_out(out_t), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rd_t));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one bit time: drive, compare against the model, then advance the model
  task automatic step(input logic fe, input logic ft, input logic w,
                      input logic [7:0] a, input logic [7:0] d, input string tag);
    int pe, pt, q, ch;
    logic se, st, en, ee, et;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fs_e = fe; fs_t = ft; tx = lfsr[0]; rx = lfsr[7];
    wr = w; addr = a; wdata = d;
    #1;
    pe = fe ? 0 : pos_e;
    ch = pe / 8;
    se = (pe % 8 == 0) ? map_m[ch] : hold_e;
    ee = se ? rx : tx;
    chk(out_e == ee, tag != "" ? tag : (se ? "R1" : "R2"), out_e, ee);
    pt = ft ? 0 : pos_t;
    if (pt == 0) begin
      st = 1'b0;
      et = tx;
      chk(out_t == et, tag != "" ? tag : "R7", out_t, et);
    end else begin
      q = pt - 1; ch = q / 8;
      en = (ch < 24) ? map_m[ch] : 1'b0;
      st = (q % 8 == 0) ? en : hold_t;
      et = st ? rx : tx;
      chk(out_t == et, tag != "" ? tag : (st ? "R1" : "R2"), out_t, et);
    end
    @(posedge clk);
    if (w && a >= 8'h4B && a <= 8'h4E) map_m[8*(a-8'h4B) +: 8] = d;
    hold_e = se; hold_t = st;
    pos_e = (pe == LEN_E-1) ? 0 : pe + 1;
    pos_t = (pt == LEN_T-1) ? 0 : pt + 1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(pos_e == 0, pos_t == 0, 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    step(pos_e == 0, pos_t == 0, 1'b1, a, d, "");
  endtask

  task automatic wmap(input logic [31:0] m);
    for (int i = 0; i < 4; i++) wreg(8'h4B + 8'(i), m[8*i +: 8]);
  endtask

  task automatic rchk(input logic [7:0] a, input logic [7:0] e, input string req);
    step(pos_e == 0, pos_t == 0, 1'b0, a, 8'h00, "");
    #1;
    chk(rd_e == e, req, rd_e, e);
    chk(rd_t == e, req, rd_t, e);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R3: registers read zero while held in reset
    for (int i = 0; i < 4; i++) begin
      addr = 8'h4B + 8'(i); #1;
      chk(rd_e == 8'h00, "R3", rd_e, 0);
      chk(rd_t == 8'h00, "R3", rd_t, 0);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) rchk(8'h4B + 8'(i), 8'h00, "R3");
    idle(2 * LEN_E, "");                       // R2: all channels pass through

    wmap(32'hFFFF_FFFF);                       // R1: all channels looped
    for (int i = 0; i < 4; i++) rchk(8'h4B + 8'(i), 8'hFF, "R4");
    idle(2 * LEN_E, "");

    for (int k = 0; k < 32; k++) begin         // R5: walking single channel
      wmap(32'h1 << k);
      idle(LEN_E, "");
    end
    wmap(32'h5555_5555); idle(LEN_E, "R5");
    wmap(32'hAAAA_AAAA); idle(LEN_E, "R5");
    for (int k = 0; k < 6; k++) begin
      wmap({lfsr, lfsr ^ 16'h3C5A});
      idle(LEN_E, "R5");
    end

    // R4: distinct bytes per register, unmapped addresses
    wmap(32'h7856_3412);
    rchk(8'h4B, 8'h12, "R4"); rchk(8'h4C, 8'h34, "R4");
    rchk(8'h4D, 8'h56, "R4"); rchk(8'h4E, 8'h78, "R4");
    rchk(8'h4A, 8'h00, "R4"); rchk(8'h4F, 8'h00, "R4");
    wreg(8'h4F, 8'hFF); wreg(8'h4A, 8'hFF);
    rchk(8'h4B, 8'h12, "R4"); rchk(8'h4E, 8'h78, "R4");

    // R8: writes in the middle of channels
    wmap(32'h0);
    while (pos_e != 8 * 5 + 3) idle(1, "R8");
    wreg(8'h4B, 8'hFF);
    idle(20, "R8");
    wreg(8'h4C, 8'h0F);
    idle(LEN_E, "R8");

    // R6: frame sync forced mid-frame
    wmap(32'h0F0F_3C3C);
    while (pos_e != 100) idle(1, "R6");
    step(1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R6");
    idle(LEN_E, "R6");
    while (pos_e != 37) idle(1, "R6");
    step(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R6");
    idle(LEN_E, "R6");

    // R9: upper enables stored but ignored in the 24-channel build
    wmap(32'hFF00_0000);
    rchk(8'h4E, 8'hFF, "R9");
    idle(2 * LEN_E, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule